// File: doc/BRIEF.md
# Twelve-Function Select ALU

This block is a purely combinational arithmetic-logic unit for two operands of parameterised width. A four-bit select chooses one of twelve functions. When the top select bit is low, a single unsigned ripple adder forms one of eight results, chosen by the lower three bits. Those three bits only steer what feeds the adder: a constant, the second operand, its complement, or all ones, plus a carry-in. When the top select bit is high, a per-bit logic unit gives AND, OR, XOR or the complement of the first operand.

Both units evaluate on every input change. A final two-way multiplexer, controlled by the top select bit, routes one of them to the result. The carry out is forced low in logic mode, so it never depends on the unused adder. A datapath stage places the block between operand registers and a result register. It has no clock of its own.

Top module: `alu4s_core`

## Requirements
- R1: With sel[3]=0, g equals, modulo 2^W, the value for sel[2:0]: 000 x, 001 x+1, 010 x+y, 011 x+y+1, 100 x+~y, 101 x+~y+1, 110 x+(all ones), 111 x+(all ones)+1.
- R2: With sel[3]=0, co is bit W of the full-width sum behind R1. For example, code 111 always gives co=1, and code 110 gives co=0 only when x is zero.
- R3: With sel[3]=1 and sel[1:0]=00, g is the bitwise AND of x and y.
- R4: With sel[3]=1 and sel[1:0]=01, g is the bitwise OR of x and y.
- R5: With sel[3]=1 and sel[1:0]=10, g is the bitwise XOR of x and y.
- R6: With sel[3]=1 and sel[1:0]=11, g is the bitwise complement of x. Changing y has no effect on g.
- R7: With sel[3]=1, sel[2] has no effect on g or co.
- R8: With sel[3]=1, co is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | W | First operand; it is always the adder's direct input |
| y | input | W | Second operand |
| sel | input | 4 | Function select; bit 3 chooses logic (1) or arithmetic (0) |
| g | output | W | Result |
| co | output | 1 | Adder carry out in arithmetic mode, 0 in logic mode |

## Verification
The embedded checks are immediate assertions. They assume that x, y and sel carry only 0 and 1 and that the netlist has settled when each check is evaluated. Because the block is combinational, a check that fires during a transient would be meaningless. The bench therefore changes all inputs together once per cycle and compares the outputs half a cycle later. At the default width of four, it covers every select code against every operand pair, so both values of sel[2] in logic mode are included. It then holds x with the complement code and sweeps y.

// File: rtl/alu4s_pkg.sv
package alu4s_pkg;

    typedef enum logic [1:0] {
        LG_AND  = 2'b00,
        LG_OR   = 2'b01,
        LG_XOR  = 2'b10,
        LG_NOTX = 2'b11
    } logic_op_e;

    // source of the adder's second input, decoded from sel[2:1]
    typedef enum logic [1:0] {
        ASRC_ZERO = 2'b00,
        ASRC_Y    = 2'b01,
        ASRC_YINV = 2'b10,
        ASRC_ONES = 2'b11
    } add_src_e;

    typedef struct packed {
        logic      is_logic;
        add_src_e  a_src;
        logic      cin;
        logic_op_e lop;
    } sel_dec_t;

    function automatic sel_dec_t decode_sel(input logic [3:0] s);
        sel_dec_t d;
        d.is_logic = s[3];
        d.a_src    = add_src_e'(s[2:1]);
        d.cin      = s[0];
        d.lop      = logic_op_e'(s[1:0]);
        return d;
    endfunction

endpackage

// File: rtl/alu4s_arith.sv
module alu4s_arith
    import alu4s_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  add_src_e     a_src,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);

    logic [W-1:0] a_in;

    // per-bit operand steering: a = s2 & ~y | s1 & y
    for (genvar gi = 0; gi < W; gi++) begin : g_asel
        always_comb begin
            unique case (a_src)
                ASRC_ZERO: a_in[gi] = 1'b0;
                ASRC_Y:    a_in[gi] = y[gi];
                ASRC_YINV: a_in[gi] = ~y[gi];
                default:   a_in[gi] = 1'b1;
            endcase
        end
    end

    // ripple adder
    always_comb begin
        logic c;
        c = cin;
        for (int i = 0; i < W; i++) begin
            res[i] = a_in[i] ^ x[i] ^ c;
            c      = (a_in[i] & x[i]) | (c & (a_in[i] ^ x[i]));
        end
        cout = c;
    end

    always_comb begin
        // R1
        if (a_src == ASRC_ZERO && !cin)
            zero_pass_chk: assert (res == x && cout == 1'b0)
                else $error("R1 transfer through zero source altered x");
        // R2
        if (a_src == ASRC_ONES && cin)
            ones_wrap_chk: assert (res == x && cout == 1'b1)
                else $error("R2 all-ones plus carry did not wrap to x");
    end

endmodule

// File: rtl/alu4s_logic.sv
module alu4s_logic
    import alu4s_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic_op_e    lop,
    output logic [W-1:0] res
);

    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        always_comb begin
            unique case (lop)
                LG_AND:  res[gi] = x[gi] & y[gi];
                LG_OR:   res[gi] = x[gi] | y[gi];
                LG_XOR:  res[gi] = x[gi] ^ y[gi];
                default: res[gi] = ~x[gi];
            endcase
        end
    end

    always_comb begin
        // R6
        if (lop == LG_NOTX)
            notx_chk: assert ((res ^ x) == {W{1'b1}})
                else $error("R6 complement result depends on more than x");
    end

endmodule

// File: rtl/alu4s_outmux.sv
module alu4s_outmux #(
    parameter int W = 4
) (
    input  logic         pick_logic,
    input  logic [W-1:0] arith_res,
    input  logic         arith_co,
    input  logic [W-1:0] logic_res,
    output logic [W-1:0] g,
    output logic         co
);

    always_comb begin
        g  = pick_logic ? logic_res : arith_res;
        co = pick_logic ? 1'b0 : arith_co;
    end

endmodule

// File: rtl/alu4s_core.sv
module alu4s_core
    import alu4s_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [3:0]   sel,
    output logic [W-1:0] g,
    output logic         co
);

    sel_dec_t     dec;
    logic [W-1:0] ar_res;
    logic         ar_co;
    logic [W-1:0] lg_res;

    always_comb dec = decode_sel(sel);

    alu4s_arith #(.W(W)) u_arith (
        .x     (x),
        .y     (y),
        .a_src (dec.a_src),
        .cin   (dec.cin),
        .res   (ar_res),
        .cout  (ar_co)
    );

    alu4s_logic #(.W(W)) u_logic (
        .x   (x),
        .y   (y),
        .lop (dec.lop),
        .res (lg_res)
    );

    alu4s_outmux #(.W(W)) u_mux (
        .pick_logic (dec.is_logic),
        .arith_res  (ar_res),
        .arith_co   (ar_co),
        .logic_res  (lg_res),
        .g          (g),
        .co         (co)
    );

    always_comb begin
        // R8
        if (sel[3])
            logic_co_zero_chk: assert (co == 1'b0)
                else $error("R8 carry out high in logic mode");
        // R7
        if (sel[3])
            logic_route_chk: assert (g == lg_res)
                else $error("R7 logic-mode result not from logic unit");
        // R1
        if (!sel[3])
            arith_route_chk: assert (g == ar_res && co == ar_co)
                else $error("R1 arithmetic-mode result not from adder");
    end

endmodule

// File: tb/test_alu4s_core.sv
module test_alu4s_core;

    localparam int W = 4;
    localparam int M = 1 << W;

    typedef struct {
        logic [W-1:0] g;
        logic         co;
        logic [3:0]   s;
        logic [W-1:0] xv;
        logic [W-1:0] yv;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] x = '0;
    logic [W-1:0] y = '0;
    logic [3:0]   sel = '0;
    logic [W-1:0] g;
    logic         co;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #10 clk = ~clk;

    alu4s_core #(.W(W)) i_alu4s_core (
        .x(x), .y(y), .sel(sel), .g(g), .co(co)
    );

    function automatic exp_t model(input logic [W-1:0] xv, input logic [W-1:0] yv,
                                   input logic [3:0] s);
        exp_t e;
        int   t;
        int   ones;
        ones = M - 1;
        e.s = s; e.xv = xv; e.yv = yv; e.co = 1'b0;
        if (!s[3]) begin
            case (s[2:0])
                3'd0: t = xv;
                3'd1: t = xv + 1;
                3'd2: t = xv + yv;
                3'd3: t = xv + yv + 1;
                3'd4: t = xv + (ones - yv);
                3'd5: t = xv + (ones - yv) + 1;
                3'd6: t = xv + ones;
                default: t = xv + ones + 1;
            endcase
            e.g  = t[W-1:0];
            e.co = t[W];
        end else begin
            case (s[1:0])
                2'd0: e.g = xv & yv;
                2'd1: e.g = xv | yv;
                2'd2: e.g = xv ^ yv;
                default: e.g = ~xv;
            endcase
        end
        return e;
    endfunction

    function automatic string req_of(input logic [3:0] s, input bit for_co);
        if (!s[3]) return for_co ? "R2" : "R1";
        if (for_co) return "R8";
        case (s[1:0])
            2'd0: return s[2] ? "R7/R3" : "R3";
            2'd1: return s[2] ? "R7/R4" : "R4";
            2'd2: return s[2] ? "R7/R5" : "R5";
            default: return s[2] ? "R7/R6" : "R6";
        endcase
    endfunction

    task automatic drive(input logic [W-1:0] xv, input logic [W-1:0] yv,
                         input logic [3:0] s);
        @(posedge clk);
        x <= xv; y <= yv; sel <= s;
        sb_q.push_back(model(xv, yv, s));
    endtask

    // monitor: compare half a cycle after each drive
    always @(negedge clk) begin
        if (!rst && sb_q.size() != 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (g !== e.g) begin
                errors++;
                $display("FAIL %s sel=%b x=%h y=%h g=%h expected %h",
                         req_of(e.s, 1'b0), e.s, e.xv, e.yv, g, e.g);
            end
            checks++;
            if (co !== e.co) begin
                errors++;
                $display("FAIL %s sel=%b x=%h y=%h co=%b expected %b",
                         req_of(e.s, 1'b1), e.s, e.xv, e.yv, co, e.co);
            end
        end
    end

    initial begin
        logic [W-1:0] held;
        repeat (3) @(posedge clk);
        rst <= 1'b0;
        // reset state: all-zero inputs give transfer of zero (R1, R2)
        @(negedge clk);
        checks++;
        if (g !== '0 || co !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset-state g=%h co=%b expected 0 0", g, co);
        end
        // exhaustive sweep: R1..R8 including both sel[2] values in logic mode
        for (int s = 0; s < 16; s++)
            for (int a = 0; a < M; a++)
                for (int b = 0; b < M; b++)
                    drive(W'(a), W'(b), 4'(s));
        // R6: hold x under complement code, sweep y, g must stay constant
        drive(W'(5), '0, 4'b1011);
        @(negedge clk);
        held = g;
        for (int b = 0; b < M; b++) begin
            @(posedge clk);
            y <= W'(b);
            @(negedge clk);
            checks++;
            if (g !== held) begin
                errors++;
                $display("FAIL R6 y=%h changed g=%h expected %h", W'(b), g, held);
            end
        end
        repeat (2) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        for (int n = 0; n < 20000; n++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule